// File: doc/BRIEF.md
# Match-Clearing Real-Time Counter

This block keeps elapsed time as a 40-bit count of prescaled ticks. A free-running 7-bit prescaler turns every 128 cycles of the slow source clock into a one-cycle count enable. A 32.768 kHz source therefore advances the count 256 times per second. The whole block runs in that single clock domain, and no clock is derived from the prescaler.

A 40-bit compare register sits beside the counter. The `matchHit` output is high exactly when every counter bit equals the corresponding compare bit. When host logic sets the auto-clear bit, a tick that arrives while the two values are equal returns the counter to zero instead of incrementing it. The all-zero count is exempt, because a counter cleared at zero would never leave zero.

Host logic reaches the block through a byte-wide register port with one-cycle read latency. A read of the lowest counter byte latches all 40 counter bits into a hold register. The upper counter bytes are then read from that latched copy, so the bytes of a multi-byte read stay coherent while counting continues.

Top module: `rtc_match_counter`

## Requirements
- R1: After reset the counter and the compare register are zero, `matchHit` is 1, and the control register reads 0x80 (counting off, auto-clear off, bit 7 = match).
- R2: With counting enabled and auto-clear off, the counter advances by exactly one per 128 clock cycles, and the prescaler tick is never high for two cycles in a row.
- R3: With control bit 0 (count enable) clear, the counter holds its value. Setting the bit again resumes counting from the held value.
- R4: With control bit 1 (auto-clear) set, a tick that occurs while the counter equals the compare register and is nonzero loads zero into the counter.
- R5: A tick while the counter is zero always loads one, even when the compare register is zero and auto-clear is on.
- R6: `matchHit` is 1 only when all 40 counter bits equal the compare register, and control bit 7 reads back the same value.
- R7: Register offsets: 0–4 are the counter bytes, least significant first; 5–9 are the compare bytes, least significant first; 10 is control. Read data appears one cycle after `rdEn`. Unmapped offsets read 0. Control bits 2–7 ignore writes.
- R8: A read of offset 0 returns the live low byte and latches the whole counter. Reads of offsets 1–4 return bytes of that latched value, not of the advancing counter.
- R9: A write to any counter byte takes priority over an increment or auto-clear in the same cycle. In that cycle the other counter bytes keep their values.
- R10: With auto-clear off, the counter counts through the compare value without clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock (crystal rate) |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid the cycle after `rdEn` |
| matchHit | output | 1 | Counter equals compare register |

## Verification
The embedded properties check on every cycle that the count holds when there is no tick or enable, that writes override counting, that zero always steps to one, that auto-clear loads zero, that the hold register changes only on a low-byte read, and that ticks are single-cycle pulses. Only the bench scenarios can show the tick rate of one per 128 cycles, the resumption after a pause, and the coherence of multi-byte reads taken while the counter advances. The register map decode and the reserved control bits are also shown only by those scenarios.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_BYTES = 5;
  localparam int RTC_W     = 8 * RTC_BYTES;

  typedef struct packed {
    logic [RTC_BYTES-1:0] cntWr;
    logic [RTC_BYTES-1:0] cmpWr;
    logic                 snap;
    logic                 inc;
    logic                 clrEn;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESC_BITS = 7,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        cntLow,
  input  logic [RTC_W-9:0]  holdHi,
  input  logic [RTC_W-1:0]  cmpVal,
  input  logic              matchHit,
  output rtcStrobe_t        strobe,
  output logic [7:0]        rdData
);
  localparam int CMP_BASE  = RTC_BYTES;
  localparam int CTRL_ADDR = 2 * RTC_BYTES;

  logic [PRESC_BITS-1:0] presc;
  logic                  tick;
  logic                  cntEn;
  logic                  clrEn;
  logic                  ctrlWr;
  logic [7:0]            rdNext;

  // Free-running prescaler; a tick is a one-cycle enable, never a clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end
  assign tick = &presc;

  assign ctrlWr = wrEn && (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn <= 1'b0;
      clrEn <= 1'b0;
    end else if (ctrlWr) begin
      cntEn <= wrData[0];
      clrEn <= wrData[1];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < RTC_BYTES; gi++) begin : g_dec
      assign strobe.cntWr[gi] = wrEn && (addr == ADDR_W'(gi));
      assign strobe.cmpWr[gi] = wrEn && (addr == ADDR_W'(CMP_BASE + gi));
    end
  endgenerate

  assign strobe.snap  = rdEn && (addr == '0);
  assign strobe.inc   = tick && cntEn;
  assign strobe.clrEn = clrEn;

  always_comb begin
    rdNext = '0;
    if (addr == '0) rdNext = cntLow;
    for (int i = 1; i < RTC_BYTES; i++)
      if (addr == ADDR_W'(i)) rdNext = holdHi[8*(i-1) +: 8];
    for (int i = 0; i < RTC_BYTES; i++)
      if (addr == ADDR_W'(CMP_BASE + i)) rdNext = cmpVal[8*i +: 8];
    if (addr == ADDR_W'(CTRL_ADDR)) rdNext = {matchHit, 5'b0, clrEn, cntEn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (cntEn == $past(wrData[0])) && (clrEn == $past(wrData[1])));
endmodule

// File: rtl/rtc_data.sv
module rtc_data
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strobe,
  input  logic [7:0]       wrData,
  output logic [RTC_W-1:0] cnt,
  output logic [RTC_W-1:0] cmpReg,
  output logic [RTC_W-1:0] hold,
  output logic             matchHit
);
  logic anyCntWr;
  logic cntNonZero;

  assign anyCntWr   = |strobe.cntWr;
  assign cntNonZero = |cnt;
  assign matchHit   = &(cnt ~^ cmpReg);

  // Host writes win over counting; auto-clear skips the all-zero count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (anyCntWr) begin
      for (int i = 0; i < RTC_BYTES; i++)
        if (strobe.cntWr[i]) cnt[8*i +: 8] <= wrData;
    end else if (strobe.inc) begin
      if (strobe.clrEn && matchHit && cntNonZero) cnt <= '0;
      else                                        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else begin
      for (int i = 0; i < RTC_BYTES; i++)
        if (strobe.cmpWr[i]) cmpReg[8*i +: 8] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hold <= '0;
    else if (strobe.snap) hold <= cnt;
  end

  genvar gb;
  generate
    for (gb = 0; gb < RTC_BYTES; gb++) begin : g_chk
      p_wr_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
        strobe.cntWr[gb] |=> cnt[8*gb +: 8] == $past(wrData));
    end
  endgenerate

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !anyCntWr) |=> $stable(cnt));

  p_self_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && strobe.clrEn && matchHit && cntNonZero && !anyCntWr) |=> cnt == '0);

  p_zero_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !cntNonZero && !anyCntWr) |=> cnt == RTC_W'(1));

  p_snapshot_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.snap |=> $stable(hold));
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_pkg::*;
#(
  parameter int PRESC_BITS = 7,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              matchHit
);
  rtcStrobe_t       strobe;
  logic [RTC_W-1:0] cnt;
  logic [RTC_W-1:0] cmpReg;
  logic [RTC_W-1:0] hold;
  logic [7:0]       holdLowUnused;

  assign holdLowUnused = hold[7:0];

  rtc_ctrl #(.PRESC_BITS(PRESC_BITS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntLow(cnt[7:0]), .holdHi(hold[RTC_W-1:8]),
    .cmpVal(cmpReg), .matchHit(matchHit), .strobe(strobe), .rdData(rdData)
  );

  rtc_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cnt(cnt), .cmpReg(cmpReg), .hold(hold), .matchHit(matchHit)
  );

  p_rst_match_r1: assert property (@(posedge clk)
    !rstN |=> (rstN || matchHit));
endmodule

// File: tb/rtc_match_counter_test.sv
module rtc_match_counter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       matchHit;
  logic       rdFired = 1'b0;

  int total = 0;
  int bad = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  rtc_match_counter uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .matchHit(matchHit)
  );

  always @(posedge clk) rdFired <= rdEn;

  // Monitor: read data is valid the cycle after the strobe.
  always @(negedge clk) begin
    if (rdFired && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (rdData !== e) begin
        bad++;
        $display("FAIL %s: rdData=%02h expected=%02h", t, rdData, e);
      end
    end
  end

  task automatic checkBit(input logic act, input logic exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCnt(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(i), v[8*i +: 8]);
  endtask

  task automatic wrCmp(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(5 + i), v[8*i +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkBit(matchHit, 1'b1, "R1 match during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkBit(matchHit, 1'b1, "R1 match after reset");
    rd(4'd10, 8'h80, "R1 ctrl reset value");
    rd(4'd0, 8'h00, "R1 counter reset");
    rd(4'd7, 8'h00, "R1 compare reset");

    // R7 map and reserved bits
    rd(4'd11, 8'h00, "R7 unmapped offset");
    wr(4'd10, 8'hFC);
    rd(4'd10, 8'h80, "R7 reserved ctrl bits");

    // R6 equality
    wrCnt(40'h1);
    checkBit(matchHit, 1'b0, "R6 mismatch low byte");
    rd(4'd10, 8'h00, "R6 ctrl bit7 clear");
    wrCmp(40'h1);
    checkBit(matchHit, 1'b1, "R6 equal values");
    wrCmp(40'h01_0000_0001);
    checkBit(matchHit, 1'b0, "R6 mismatch top byte");
    rd(4'd9, 8'h01, "R7 compare top byte");

    // R2 / R10: count through compare value, auto-clear off
    wrCnt(40'h3); wrCmp(40'h5);
    wr(4'd10, 8'h01);
    idle(128 * 4);
    rd(4'd0, 8'h07, "R2 R10 four ticks past compare");
    rd(4'd1, 8'h00, "R8 held upper byte");
    wr(4'd10, 8'h00);

    // R3 hold while disabled, then resume
    wrCnt(40'h20);
    idle(300);
    rd(4'd0, 8'h20, "R3 held while disabled");
    wr(4'd10, 8'h01);
    idle(128 * 2);
    rd(4'd0, 8'h22, "R3 resume from held value");
    wr(4'd10, 8'h00);

    // R4 auto-clear on match
    wrCnt(40'h3); wrCmp(40'h5);
    wr(4'd10, 8'h03);
    idle(128 * 3);
    rd(4'd0, 8'h00, "R4 clear after match");
    wr(4'd10, 8'h00);

    // R5 zero never clears
    wrCnt(40'h0); wrCmp(40'h0);
    checkBit(matchHit, 1'b1, "R5 zero equals zero");
    wr(4'd10, 8'h03);
    idle(128 * 2);
    rd(4'd0, 8'h02, "R5 zero steps past compare");
    wr(4'd10, 8'h00);

    // R8 coherent read
    wrCnt(40'h12_3456_78FF);
    wr(4'd10, 8'h01);
    rd(4'd0, 8'hFF, "R8 low byte latch");
    idle(256);
    rd(4'd1, 8'h78, "R8 byte1 from snapshot");
    rd(4'd4, 8'h12, "R8 byte4 from snapshot");
    wr(4'd10, 8'h00);

    // R9 write beats increment
    wrCnt(40'h10);
    wr(4'd10, 8'h01);
    for (int i = 0; i < 128; i++) wr(4'd1, 8'h00);
    rd(4'd0, 8'h10, "R9 writes suppress increment");
    wr(4'd10, 8'h00);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule